// File: doc/BRIEF.md
# Indirect Interrupt-File Register Window

This block is the register window a hart uses to reach an interrupt file through a select index rather than a flat address map. Each request carries a select index, the requester's privilege level, a virtualization flag, a guest-page number, an access width (32 or 64 bits), write data and a per-bit write mask. The block works out which page of the file is targeted and whether the access is allowed. It then reads and updates a word of the per-identity pending or enable bits, or hands a control-register access to the neighbouring priority logic.

The pending and enable bits of every page are held here and exported as flat vectors for the priority logic. Control registers (delivery enable and threshold) live next door: an accepted control access produces a one-cycle strobe carrying page, register choice, data and mask, and the neighbour answers on `ctl_rdata` in that same cycle.

Requests and responses use valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its state update happens on that edge, and its response appears on the next cycle. `req_ready` is high whenever no response is waiting or the waiting one is being taken. A response that is not taken holds its data and flag unchanged until `rsp_ready` rises.

Top module: `imsic_reg_window`

## Requirements
- R1: With M_MODE=0 (supervisor file), privilege 1 (supervisor) with the virtualization flag low targets page 0. With the flag high it targets the page equal to the guest number, and a guest number of 0 or of at least NUM_PAGES is illegal.
- R2: With M_MODE=1 (machine file), an access is legal only at privilege 3 (machine) with the virtualization flag low, and it targets page 0.
- R3: Privilege 0 (user) is always illegal, and so is any privilege other than the one that R1 or R2 allows. Any select other than 0x70, 0x72 or 0x80 to 0xFF is illegal.
- R4: Select 0x80+k addresses pending word k and 0xC0+k addresses enable word k, for k from 0 to 63. Word k covers the identities from k*32 upward, with data bit b mapping to identity k*32+b. A 32-bit access (`req_wide`=0) covers 32 identities.
- R5: For a 64-bit access (`req_wide`=1), an odd k is illegal. An even k covers the 64 identities from k*32 upward.
- R6: A word is illegal when k is at least NUM_IDS/32 for a 32-bit access, or when k/2 is at least NUM_IDS/64 for a 64-bit access.
- R7: Identity 0 of every page reads as 0 in both arrays and ignores writes.
- R8: A bit is updated only where its mask bit is 1, taking the data bit. The response returns the contents from before the write. A 32-bit access returns zeros in bits 63:32 and uses only the low 32 mask bits.
- R9: An illegal access returns `rsp_illegal`=1 with zero data, changes no array bit and raises no control strobe.
- R10: A legal access to select 0x70 (delivery) or 0x72 (threshold) raises `ctl_valid` for exactly the accepting cycle. The strobe carries the resolved page, `ctl_thr`=1 for 0x72, and the data and mask, which are cut to 32 bits for a 32-bit access. The response returns `ctl_rdata` as sampled in that cycle, also cut to the access width.
- R11: The response is valid in the cycle after acceptance. `req_ready` equals NOT `rsp_valid` OR `rsp_ready`. A pending response keeps its data and flag stable while `rsp_ready` is low.
- R12: After reset, `rsp_valid` is 0 and every pending and enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_sel | input | 8 | Register select index |
| req_priv | input | 2 | Requester privilege (0 user, 1 supervisor, 3 machine) |
| req_virt | input | 1 | Requester is virtualized |
| req_guest | input | GUEST_W | Guest page number |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit |
| req_wdata | input | 64 | Write data |
| req_wmask | input | 64 | Per-bit write enable |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 64 | Pre-write read data |
| rsp_illegal | output | 1 | Access was rejected |
| ctl_valid | output | 1 | Control-register access strobe |
| ctl_page | output | PAGE_W | Page of the control access |
| ctl_thr | output | 1 | 1 = threshold, 0 = delivery |
| ctl_wdata | output | 64 | Control write data |
| ctl_wmask | output | 64 | Control write mask |
| ctl_rdata | input | 64 | Control register value from neighbour |
| pend_o | output | NUM_PAGES*NUM_IDS | Pending bits, page p at [p*NUM_IDS +: NUM_IDS] |
| enab_o | output | NUM_PAGES*NUM_IDS | Enable bits, same layout |

## Verification
The hardest situation to reach is a 64-bit write that straddles the 32-bit word boundary, issued while a previous response is still stalled. The bench therefore mixes 64-bit writes at even indices with a response-ready pattern that drops periodically, and it also holds ready low on purpose. That way, several accepted updates and stalled responses overlap. A second instance built as a machine file receives the same request stream, so every privilege and virtualization combination is judged under both legality rules at once. Illegal writes carrying all-ones data are followed by reads and a final comparison of the exported arrays, which shows that they left nothing behind.

// File: rtl/imsic_win_pkg.sv
package imsic_win_pkg;

  typedef enum logic [2:0] {
    K_NONE   = 3'd0,
    K_DELIV  = 3'd1,
    K_THRESH = 3'd2,
    K_PEND   = 3'd3,
    K_ENAB   = 3'd4
  } win_kind_e;

  localparam logic [7:0] SEL_DELIV  = 8'h70;
  localparam logic [7:0] SEL_THRESH = 8'h72;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

endpackage

// File: rtl/imsic_win_decode.sv
module imsic_win_decode
  import imsic_win_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  parameter int NUM_IDS   = 128,
  parameter bit M_MODE    = 1'b0,
  parameter int GUEST_W   = 6,
  parameter int PAGE_W    = 2
) (
  input  logic [7:0]         sel,
  input  logic [1:0]         priv,
  input  logic               virt,
  input  logic [GUEST_W-1:0] guest,
  input  logic               wide,
  output logic               ok,
  output win_kind_e          kind,
  output logic [PAGE_W-1:0]  page,
  output logic [5:0]         word
);
  localparam int WORDS32 = NUM_IDS / 32;
  localparam int WORDS64 = NUM_IDS / 64;

  logic priv_ok;
  logic word_ok;

  // privilege / virtualization -> page
  always_comb begin
    priv_ok = 1'b0;
    page    = '0;
    if (M_MODE) begin
      priv_ok = (priv == PRIV_M) && !virt;
    end else if (priv == PRIV_S) begin
      if (!virt) begin
        priv_ok = 1'b1;
      end else if ((guest != '0) && (32'(guest) < 32'(NUM_PAGES))) begin
        priv_ok = 1'b1;
        page    = PAGE_W'(guest);
      end
    end
  end

  // select index -> register kind and word index
  always_comb begin
    word = sel[5:0];
    if (sel == SEL_DELIV)        kind = K_DELIV;
    else if (sel == SEL_THRESH)  kind = K_THRESH;
    else if (sel[7:6] == 2'b10)  kind = K_PEND;
    else if (sel[7:6] == 2'b11)  kind = K_ENAB;
    else                         kind = K_NONE;
  end

  always_comb begin
    if (wide) word_ok = !word[0] && (32'(word[5:1]) < 32'(WORDS64));
    else      word_ok = 32'(word) < 32'(WORDS32);
    ok = priv_ok && (kind != K_NONE) &&
         (((kind == K_PEND) || (kind == K_ENAB)) ? word_ok : 1'b1);
  end

endmodule

// File: rtl/imsic_win_array.sv
module imsic_win_array #(
  parameter int NUM_PAGES = 4,
  parameter int NUM_IDS   = 128,
  parameter int PAGE_W    = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [PAGE_W-1:0]              page,
  input  logic [5:0]                     word,
  input  logic                           wide,
  input  logic [63:0]                    wdata,
  input  logic [63:0]                    wmask,
  output logic [63:0]                    rdata,
  output logic [NUM_PAGES*NUM_IDS-1:0]   bits_o
);
  logic [NUM_PAGES-1:0][NUM_IDS-1:0] mem;
  logic [31:0] base;

  // word k starts at identity k*32 for both widths
  assign base = 32'({word, 5'b0});

  always_comb begin
    rdata = '0;
    for (int b = 0; b < 64; b++) begin
      if (((b < 32) || wide) && ((base + 32'(b)) < 32'(NUM_IDS)))
        rdata[b] = mem[page][base + 32'(b)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (we) begin
      for (int b = 0; b < 64; b++) begin
        if (((b < 32) || wide) && wmask[b] &&
            ((base + 32'(b)) < 32'(NUM_IDS)) && ((base + 32'(b)) != 32'd0))
          mem[page][base + 32'(b)] <= wdata[b];
      end
    end
  end

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_out
    assign bits_o[p*NUM_IDS +: NUM_IDS] = mem[p];
  end

  // R9: without a write strobe the array holds
  a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem));

endmodule

// File: rtl/imsic_reg_window.sv
module imsic_reg_window
  import imsic_win_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  parameter int NUM_IDS   = 128,
  parameter bit M_MODE    = 1'b0,
  parameter int GUEST_W   = 6,
  parameter int PAGE_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [7:0]                    req_sel,
  input  logic [1:0]                    req_priv,
  input  logic                          req_virt,
  input  logic [GUEST_W-1:0]            req_guest,
  input  logic                          req_wide,
  input  logic [63:0]                   req_wdata,
  input  logic [63:0]                   req_wmask,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [63:0]                   rsp_rdata,
  output logic                          rsp_illegal,
  output logic                          ctl_valid,
  output logic [PAGE_W-1:0]             ctl_page,
  output logic                          ctl_thr,
  output logic [63:0]                   ctl_wdata,
  output logic [63:0]                   ctl_wmask,
  input  logic [63:0]                   ctl_rdata,
  output logic [NUM_PAGES*NUM_IDS-1:0]  pend_o,
  output logic [NUM_PAGES*NUM_IDS-1:0]  enab_o
);
  localparam logic [63:0] LOW32 = 64'h0000_0000_FFFF_FFFF;

  logic              acc;
  logic              dec_ok;
  win_kind_e         dec_kind;
  logic [PAGE_W-1:0] dec_page;
  logic [5:0]        dec_word;
  logic [63:0]       width_mask;
  logic              pend_we, enab_we;
  logic [63:0]       pend_rd, enab_rd;
  logic [63:0]       rd_sel;

  assign req_ready  = !rsp_valid || rsp_ready;
  assign acc        = req_valid && req_ready;
  assign width_mask = req_wide ? '1 : LOW32;

  imsic_win_decode #(
    .NUM_PAGES(NUM_PAGES), .NUM_IDS(NUM_IDS), .M_MODE(M_MODE),
    .GUEST_W(GUEST_W), .PAGE_W(PAGE_W)
  ) u_dec (
    .sel(req_sel), .priv(req_priv), .virt(req_virt), .guest(req_guest),
    .wide(req_wide), .ok(dec_ok), .kind(dec_kind), .page(dec_page),
    .word(dec_word)
  );

  assign pend_we = acc && dec_ok && (dec_kind == K_PEND);
  assign enab_we = acc && dec_ok && (dec_kind == K_ENAB);

  imsic_win_array #(.NUM_PAGES(NUM_PAGES), .NUM_IDS(NUM_IDS), .PAGE_W(PAGE_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .we(pend_we), .page(dec_page), .word(dec_word),
    .wide(req_wide), .wdata(req_wdata), .wmask(req_wmask),
    .rdata(pend_rd), .bits_o(pend_o)
  );

  imsic_win_array #(.NUM_PAGES(NUM_PAGES), .NUM_IDS(NUM_IDS), .PAGE_W(PAGE_W)) u_enab (
    .clk(clk), .rst_n(rst_n), .we(enab_we), .page(dec_page), .word(dec_word),
    .wide(req_wide), .wdata(req_wdata), .wmask(req_wmask),
    .rdata(enab_rd), .bits_o(enab_o)
  );

  // control registers are handed to the neighbouring priority logic
  assign ctl_valid = acc && dec_ok && ((dec_kind == K_DELIV) || (dec_kind == K_THRESH));
  assign ctl_thr   = (dec_kind == K_THRESH);
  assign ctl_page  = dec_page;
  assign ctl_wdata = req_wdata & width_mask;
  assign ctl_wmask = req_wmask & width_mask;

  always_comb begin
    case (dec_kind)
      K_PEND:           rd_sel = pend_rd;
      K_ENAB:           rd_sel = enab_rd;
      K_DELIV, K_THRESH: rd_sel = ctl_rdata & width_mask;
      default:          rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_illegal <= 1'b0;
    end else if (acc) begin
      rsp_valid   <= 1'b1;
      rsp_illegal <= !dec_ok;
      rsp_rdata   <= dec_ok ? rd_sel : '0;
    end else if (rsp_ready) begin
      rsp_valid   <= 1'b0;
    end
  end

  // R11: a stalled response stays put
  a_r11_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_illegal));

  // R11: acceptance yields a response next cycle
  a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R9: rejected accesses carry no data
  a_r9_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_illegal |-> rsp_rdata == '0);

  // R10: control strobe only on an accepted request
  a_r10_ctl_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid |-> req_valid && req_ready);

  // R7: identity 0 never set in any page
  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_chk
    a_r7_id0_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_o[p*NUM_IDS] && !enab_o[p*NUM_IDS]);
  end

endmodule

// File: tb/sim_imsic_reg_window.sv
`timescale 1ns/1ps
module sim_imsic_reg_window;
  localparam int NP = 4;
  localparam int NI = 128;
  localparam int GW = 6;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0;
  logic [7:0]    req_sel = '0;
  logic [1:0]    req_priv = '0;
  logic          req_virt = 1'b0;
  logic [GW-1:0] req_guest = '0;
  logic          req_wide = 1'b0;
  logic [63:0]   req_wdata = '0, req_wmask = '0;
  logic          rsp_ready = 1'b1;
  logic          req_ready, rsp_valid, rsp_illegal, ctl_valid, ctl_thr;
  logic [63:0]   rsp_rdata, ctl_wdata, ctl_wmask, ctl_rdata;
  logic [PW-1:0] ctl_page;
  logic [NP*NI-1:0] pend_o, enab_o;

  logic          m_ready, m_valid, m_ill, m_cv, m_ct;
  logic [63:0]   m_rd, m_cwd, m_cwm;
  logic [PW-1:0] m_cp;
  logic [NP*NI-1:0] m_po, m_eo;

  assign ctl_rdata = 64'hC0DE_0000_0000_0000 | (64'(ctl_page) << 4) | 64'(ctl_thr);

  imsic_reg_window #(.NUM_PAGES(NP), .NUM_IDS(NI), .M_MODE(1'b0), .GUEST_W(GW)) u0 (
    .clk, .rst_n, .req_valid, .req_ready, .req_sel, .req_priv, .req_virt, .req_guest,
    .req_wide, .req_wdata, .req_wmask, .rsp_valid, .rsp_ready, .rsp_rdata, .rsp_illegal,
    .ctl_valid, .ctl_page, .ctl_thr, .ctl_wdata, .ctl_wmask, .ctl_rdata, .pend_o, .enab_o);

  imsic_reg_window #(.NUM_PAGES(NP), .NUM_IDS(NI), .M_MODE(1'b1), .GUEST_W(GW)) u1 (
    .clk, .rst_n, .req_valid, .req_ready(m_ready), .req_sel, .req_priv, .req_virt,
    .req_guest, .req_wide, .req_wdata, .req_wmask, .rsp_valid(m_valid), .rsp_ready,
    .rsp_rdata(m_rd), .rsp_illegal(m_ill), .ctl_valid(m_cv), .ctl_page(m_cp),
    .ctl_thr(m_ct), .ctl_wdata(m_cwd), .ctl_wmask(m_cwm), .ctl_rdata(64'd0),
    .pend_o(m_po), .enab_o(m_eo));

  int checks = 0, errors = 0;
  int ctl_seen = 0, ctl_exp = 0;
  logic [NI-1:0] pm [NP];
  logic [NI-1:0] em [NP];

  logic [63:0] q_data [$];
  logic        q_ill  [$];
  logic        q_mill [$];
  string       q_tag  [$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: computes expectations, pushes them, then presents the request
  task automatic req(input string tag, input logic [7:0] sel, input logic [1:0] pr,
                     input bit vt, input logic [GW-1:0] g, input bit wd,
                     input logic [63:0] d, input logic [63:0] m);
    bit ok_s, ok_m, arr, wok, known;
    int page, k;
    logic [63:0] rd, wm;
    k = int'(sel[5:0]);
    wm = wd ? '1 : 64'h0000_0000_FFFF_FFFF;
    arr = sel[7];
    known = (sel == 8'h70) || (sel == 8'h72) || arr;
    wok = wd ? ((k % 2 == 0) && (k / 2 < NI / 64)) : (k < NI / 32);
    page = 0;
    ok_s = 1'b0;
    if (pr == 2'd1) begin
      if (!vt) ok_s = 1'b1;
      else if (g != 0 && int'(g) < NP) begin ok_s = 1'b1; page = int'(g); end
    end
    ok_s = ok_s && known && (!arr || wok);
    ok_m = (pr == 2'd3) && !vt && known && (!arr || wok);
    rd = '0;
    if (ok_s) begin
      if (arr) begin
        for (int b = 0; b < 64; b++) begin
          int id;
          id = k * 32 + b;
          if (wm[b] && id < NI) begin
            rd[b] = sel[6] ? em[page][id] : pm[page][id];
            if (m[b] && id != 0) begin
              if (sel[6]) em[page][id] = d[b];
              else        pm[page][id] = d[b];
            end
          end
        end
      end else begin
        rd = (64'hC0DE_0000_0000_0000 | (64'(page) << 4) | 64'(sel == 8'h72)) & wm;
        ctl_exp++;
      end
    end
    q_data.push_back(rd);
    q_ill.push_back(!ok_s);
    q_mill.push_back(!ok_m);
    q_tag.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_sel = sel; req_priv = pr; req_virt = vt; req_guest = g;
    req_wide = wd; req_wdata = d; req_wmask = m;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #0.5;
    req_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (q_data.size() == 0) begin
        check(1'b0, "R11 unexpected response", 64'd1, 64'd0);
      end else begin
        logic [63:0] ed; logic ei, emi; string t;
        ed = q_data.pop_front(); ei = q_ill.pop_front();
        emi = q_mill.pop_front(); t = q_tag.pop_front();
        check(rsp_rdata == ed, {t, " data"}, rsp_rdata, ed);
        check(rsp_illegal == ei, {t, " illegal"}, 64'(rsp_illegal), 64'(ei));
        check(m_ill == emi, {"R2 machine file ", t}, 64'(m_ill), 64'(emi));
      end
    end
  end

  always @(negedge clk) if (rst_n && ctl_valid) ctl_seen++;

  // response-ready pattern
  bit hold_low = 1'b0;
  int cyc = 0;
  always @(posedge clk) begin
    #0.5;
    cyc++;
    rsp_ready = hold_low ? 1'b0 : ((cyc % 5) != 3);
  end

  initial begin
    #400000;
    check(1'b0, "watchdog", 64'd0, 64'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) begin pm[p] = '0; em[p] = '0; end
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R12 rsp_valid reset", 64'(rsp_valid), 64'd0);
    check(pend_o == '0 && enab_o == '0, "R12 arrays reset", 64'(pend_o[63:0]), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R11 ready after reset", 64'(req_ready), 64'd1);

    // R4 R7 R8 narrow pending words on page 0
    req("R7 write all word0", 8'h80, 2'd1, 0, 0, 0, '1, '1);
    req("R7 read word0",      8'h80, 2'd1, 0, 0, 0, '0, '0);
    req("R8 masked write",    8'h81, 2'd1, 0, 0, 0, 64'hFFFF_FFFF_AAAA_5555, 64'hFFFF_FFFF_0000_FFFF);
    req("R8 masked read",     8'h81, 2'd1, 0, 0, 0, '0, '0);
    // R5 wide accesses
    req("R5 wide write k2",   8'h82, 2'd1, 0, 0, 1, 64'h1234_5678_9ABC_DEF0, '1);
    req("R5 wide read k2",    8'h82, 2'd1, 0, 0, 1, '0, '0);
    req("R5 wide read k0",    8'h80, 2'd1, 0, 0, 1, '0, '0);
    req("R5 wide odd k",      8'h81, 2'd1, 0, 0, 1, '1, '1);
    req("R6 wide k4",         8'h84, 2'd1, 0, 0, 1, '1, '1);
    req("R6 narrow k4",       8'h84, 2'd1, 0, 0, 0, '1, '1);
    req("R6 narrow k3",       8'h83, 2'd1, 0, 0, 0, 64'h8000_0001, 64'hFFFF_FFFF);
    req("R4 narrow read k2",  8'h82, 2'd1, 0, 0, 0, '0, '0);
    // enable array, R7 on enable word 0
    req("R7 enable wide",     8'hC0, 2'd1, 0, 0, 1, '1, '1);
    req("R7 enable read",     8'hC0, 2'd1, 0, 0, 1, '0, '0);
    req("R4 enable k3",       8'hC3, 2'd1, 0, 0, 0, 64'h0F0F, 64'hFFFF);
    // R1 guest pages
    req("R1 guest2 write",    8'h80, 2'd1, 1, 2, 0, 64'h00F0, '1);
    req("R1 guest2 read",     8'h80, 2'd1, 1, 2, 0, '0, '0);
    req("R1 page0 intact",    8'h80, 2'd1, 0, 0, 0, '0, '0);
    req("R1 guest0 illegal",  8'h80, 2'd1, 1, 0, 0, '1, '1);
    req("R1 guest4 illegal",  8'h80, 2'd1, 1, 4, 0, '1, '1);
    req("R1 guest3 write",    8'hC1, 2'd1, 1, 3, 1, 64'hDEAD_BEEF_0000_0002, '1);
    // R2 R3 privilege
    req("R3 user illegal",    8'h81, 2'd0, 0, 0, 0, '1, '1);
    req("R2 machine priv",    8'h81, 2'd3, 0, 0, 0, '1, '1);
    req("R2 machine virt",    8'h81, 2'd3, 1, 1, 0, '1, '1);
    req("R3 sel 0x71",        8'h71, 2'd1, 0, 0, 0, '1, '1);
    req("R3 sel 0x00",        8'h00, 2'd1, 0, 0, 1, '1, '1);
    req("R9 after illegal",   8'h81, 2'd1, 0, 0, 0, '0, '0);
    // R10 control forwarding
    req("R10 delivery",       8'h70, 2'd1, 0, 0, 0, 64'h1, 64'h1);
    req("R10 threshold g1",   8'h72, 2'd1, 1, 1, 1, 64'h5, '1);
    req("R10 threshold g3",   8'h72, 2'd1, 1, 3, 0, 64'h5, '1);

    // R11 deliberate stall
    hold_low = 1'b1;
    req("R11 stalled read",   8'h83, 2'd1, 0, 0, 0, '0, '0);
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b1, "R11 held valid", 64'(rsp_valid), 64'd1);
    check(req_ready == 1'b0, "R11 ready low when stalled", 64'(req_ready), 64'd0);
    hold_low = 1'b0;

    for (int i = 0; i < 20; i++)
      req("R8 sweep", 8'hC0 + 8'(i % 4), 2'd1, 1, 6'(1 + i % 3), 0, 64'(i * 32'h9E37_79B9), 64'(i * 32'h7F4A_7C15));

    repeat (10) @(negedge clk);
    check(q_data.size() == 0, "R11 all responses seen", 64'(q_data.size()), 64'd0);
    check(ctl_seen == ctl_exp, "R10 strobe count", 64'(ctl_seen), 64'(ctl_exp));
    for (int p = 0; p < NP; p++) begin
      check(pend_o[p*NI +: NI] == pm[p], "R9 pending array final", pend_o[p*NI +: 64], pm[p][63:0]);
      check(enab_o[p*NI +: NI] == em[p], "R9 enable array final", enab_o[p*NI +: 64], em[p][63:0]);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule